// File: doc/BRIEF.md
# Macroblock Coded-Data Output Sequencer

This block puts one macroblock of compressed video onto an 8-bit byte bus on a fixed, cycle-exact schedule. A one-cycle `dclk` strobe marks the first cycle of every field that carries data. During wait cycles `dclk` stays low and `dbus` is zero. Header fields are sampled from plain input pins when a start pulse is accepted. Run/coefficient pairs for the coded sub-blocks arrive over a valid/ready stream from an external pair buffer.

Each macroblock opens with a short wait. A dummy macroblock then sends only its control byte. A normal one sends its seven header fields. If any sub-block is coded, a long gap follows, and then each coded sub-block in ascending number order. A coded sub-block is its number, then its run/coefficient pairs, then idle padding that holds the sub-block to a fixed cycle budget. A short tail with a one-cycle end pulse closes the macroblock.

Pair stream rules: `pr_ready` rises only in cycles where the sequencer needs its next pair. A pair is consumed on a clock edge where `pr_valid` and `pr_ready` are both high. While `pr_ready` is high and `pr_valid` is low, the sequencer stalls without strobing. Stall cycles count against the sub-block budget. The source must present the pairs of coded sub-blocks in ascending sub-block order, with `pr_last` set on the final pair of each sub-block.

Top module: `mbs_out_seq`

## Requirements
- R1: A start pulse is accepted only while `busy` is low, and `busy` is high from the next cycle. A start pulse while busy has no effect. After reset, `busy`, `dclk`, `dbus`, `pr_ready`, `mb_end` and `ovf_err` are all zero.
- R2: For a dummy macroblock, the control byte is strobed at cycle 2, counting the cycle after acceptance as cycle 0. Nothing else is strobed, and `mb_end` pulses at cycle 4.
- R3: For a normal macroblock, the header bytes are strobed at cycles 2, 4, 6, 8, 10, 12 and 14. The order is control, group-of-blocks, macroblock address, coded-pattern byte, quantizer, horizontal vector, vertical vector. Each byte is held on `dbus` for two cycles.
- R4: In the coded-pattern byte, `hdr_cbp[i]` (sub-block i+1 coded) appears on bit 6-i, so sub-block 1 is on bit 6 and sub-block 6 on bit 1. Bits 7 and 0 are zero. The motion-vector bytes carry the 5-bit two's complement value on bits 4:0, with bits 7:5 zero.
- R5: When `hdr_cbp` is zero, `mb_end` pulses at cycle 16 with no further strobes.
- R6: When any sub-block is coded, the first sub-block number is strobed at cycle 48, after a 32-cycle gap. Numbers 1..6 are on bits 2:0 and are held 15 cycles. Only coded sub-blocks appear, in ascending order.
- R7: Pair i of a sub-block starting at cycle s has its run byte strobed at s+15+5i and its coefficient byte at s+17+5i. The run byte carries the zero count on bits 5:0. Bits 7:6 are 11 on the sub-block's last pair and 00 otherwise.
- R8: A sub-block with n pairs and no stalls lasts max(335, 15+5n) cycles. The next sub-block number, or the tail cycle that carries `mb_end`, follows immediately after.
- R9: A pair is taken only on an edge with `pr_valid` and `pr_ready` both high. Its run byte is strobed in the next cycle. Stalls delay pairs without loss or reordering, and padding absorbs them, so sub-block start cycles do not move.
- R10: A sub-block still sending pairs when its 335-cycle budget runs out sets `ovf_err`. Its remaining pairs go out without padding. `ovf_err` stays high until reset.
- R11: `dclk` is high exactly once per field, on its first cycle, and never on wait, gap, stall, pad or tail cycles.
- R12: Header pins are sampled at acceptance. Changing them later does not alter the bytes of the current macroblock.
- R13: `mb_end` is a one-cycle pulse. `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a macroblock (honoured when idle) |
| busy | output | 1 | Macroblock in progress |
| mb_end | output | 1 | One-cycle end-of-macroblock pulse |
| ovf_err | output | 1 | Sticky sub-block budget overflow |
| hdr_dummy | input | 1 | Macroblock is a dummy |
| hdr_ctrl | input | 8 | Control byte |
| hdr_gob | input | 8 | Group-of-blocks byte |
| hdr_mba | input | 8 | Macroblock address byte |
| hdr_quant | input | 8 | Quantizer byte |
| hdr_mvx | input | 5 | Horizontal motion vector |
| hdr_mvy | input | 5 | Vertical motion vector |
| hdr_cbp | input | 6 | Coded flags, bit i = sub-block i+1 |
| pr_valid | input | 1 | Pair stream valid |
| pr_ready | output | 1 | Pair stream ready |
| pr_run | input | 6 | Zero-run count of the pair |
| pr_coef | input | 8 | Coefficient of the pair |
| pr_last | input | 1 | Final pair of its sub-block |
| dbus | output | 8 | Output data byte |
| dclk | output | 1 | Data strobe, first cycle of a field |

## Verification
All results are due at fixed offsets from the acceptance edge: header strobes at cycles 2 to 14, the first number at 48, and pairs at s+15+5i and s+17+5i. Sub-block boundaries fall every max(335, 15+5n) cycles, and the end pulse comes in the cycle after the last sub-block. The bench counts clock edges from acceptance and samples on the falling edge. It logs each strobe with its cycle number and the bus value of every cycle, then compares both with a list computed from the requirements. It also checks that each byte is still present one cycle later. In stall runs only pair timing is left unchecked, because stalls move it; byte order, sub-block starts and the end cycle are still compared.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_FLD,
    S_GAP,
    S_NUM,
    S_STALL,
    S_RUN,
    S_COEF,
    S_PGAP,
    S_PAD,
    S_TAIL
  } mbs_st_e;

  // Header fields in emission order.
  typedef enum logic [2:0] {
    F_CTRL,
    F_GOB,
    F_MBA,
    F_CBP,
    F_QUANT,
    F_MVX,
    F_MVY
  } mbs_fld_e;

endpackage

// File: rtl/mbs_fld_mux.sv
module mbs_fld_mux
  import mbs_pkg::*;
#(
  parameter int DW   = 8,
  parameter int MV_W = 5,
  parameter int NSB  = 6
) (
  input  mbs_fld_e          fld,
  input  logic [DW-1:0]     ctrl,
  input  logic [DW-1:0]     gob,
  input  logic [DW-1:0]     mba,
  input  logic [DW-1:0]     quant,
  input  logic [MV_W-1:0]   mvx,
  input  logic [MV_W-1:0]   mvy,
  input  logic [NSB-1:0]    cbp,
  output logic [DW-1:0]     byte_o
);

  logic [DW-1:0] cbp_byte;

  // Sub-block 1 lands on bit NSB, sub-block NSB on bit 1; bit 0 and top bit stay low.
  always_comb begin
    cbp_byte = '0;
    for (int i = 0; i < NSB; i++) begin
      cbp_byte[NSB-i] = cbp[i];
    end
  end

  always_comb begin
    case (fld)
      F_CTRL:  byte_o = ctrl;
      F_GOB:   byte_o = gob;
      F_MBA:   byte_o = mba;
      F_CBP:   byte_o = cbp_byte;
      F_QUANT: byte_o = quant;
      F_MVX:   byte_o = DW'(mvx);
      F_MVY:   byte_o = DW'(mvy);
      default: byte_o = '0;
    endcase
  end

endmodule

// File: rtl/mbs_pick.sv
module mbs_pick #(
  parameter int N     = 6,
  parameter int NUM_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     pend,
  output logic [NUM_W-1:0] num,
  output logic [N-1:0]     sel,
  output logic             any
);

  // Lowest pending index wins: sub-blocks go out in ascending number.
  always_comb begin
    num = '0;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        num = NUM_W'(i + 1);
        sel = N'(1) << i;
      end
    end
  end

  assign any = |pend;

endmodule

// File: rtl/mbs_budget.sv
module mbs_budget #(
  parameter int BUDGET = 335,
  parameter int BW     = $clog2(BUDGET) + 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic at_limit,
  output logic over
);

  logic [BW-1:0] sbc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbc <= '0;
    end else if (restart) begin
      sbc <= '0;
    end else if (sbc != {BW{1'b1}}) begin
      sbc <= sbc + 1'b1;
    end
  end

  assign at_limit = (sbc == BW'(BUDGET - 1));
  assign over     = (sbc >= BW'(BUDGET - 1));

endmodule

// File: rtl/mbs_out_seq.sv
module mbs_out_seq
  import mbs_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MV_W      = 5,
  parameter int NSB       = 6,
  parameter int PRE_WAIT  = 2,
  parameter int FIELD_CYC = 2,
  parameter int SB_GAP    = 32,
  parameter int NUM_CYC   = 15,
  parameter int PAIR_GAP  = 1,
  parameter int SB_BUDGET = 335,
  parameter int TAIL_CYC  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  output logic                      busy,
  output logic                      mb_end,
  output logic                      ovf_err,
  input  logic                      hdr_dummy,
  input  logic [DW-1:0]             hdr_ctrl,
  input  logic [DW-1:0]             hdr_gob,
  input  logic [DW-1:0]             hdr_mba,
  input  logic [DW-1:0]             hdr_quant,
  input  logic [MV_W-1:0]           hdr_mvx,
  input  logic [MV_W-1:0]           hdr_mvy,
  input  logic [NSB-1:0]            hdr_cbp,
  input  logic                      pr_valid,
  output logic                      pr_ready,
  input  logic [DW-3:0]             pr_run,
  input  logic [DW-1:0]             pr_coef,
  input  logic                      pr_last,
  output logic [DW-1:0]             dbus,
  output logic                      dclk
);

  localparam int RUN_W = DW - 2;
  localparam int SBN_W = $clog2(NSB + 1);
  localparam int M1    = (PRE_WAIT > FIELD_CYC) ? PRE_WAIT : FIELD_CYC;
  localparam int M2    = (SB_GAP > NUM_CYC) ? SB_GAP : NUM_CYC;
  localparam int M3    = (PAIR_GAP > TAIL_CYC) ? PAIR_GAP : TAIL_CYC;
  localparam int M12   = (M1 > M2) ? M1 : M2;
  localparam int MAXC  = (M12 > M3) ? M12 : M3;
  localparam int CW    = $clog2(MAXC + 1);

  mbs_st_e             st, st_n;
  logic [CW-1:0]       cnt;
  mbs_fld_e            fld;
  logic [NSB-1:0]      pend;
  logic [SBN_W-1:0]    sb_num;
  logic [RUN_W-1:0]    p_run;
  logic [DW-1:0]       p_coef;
  logic                p_last;

  logic                h_dummy;
  logic [DW-1:0]       h_ctrl, h_gob, h_mba, h_quant;
  logic [MV_W-1:0]     h_mvx, h_mvy;
  logic [NSB-1:0]      h_cbp;

  logic [SBN_W-1:0]    pick_num;
  logic [NSB-1:0]      pick_sel;
  logic                pend_any;
  logic                at_limit, over;
  logic                sb_enter, take, cnt_clr, ovf_set;
  logic [DW-1:0]       hdr_byte;

  logic                end_pre, end_fld, end_gap, end_num, end_pgap, end_tail;

  assign end_pre  = (cnt == CW'(PRE_WAIT - 1));
  assign end_fld  = (cnt == CW'(FIELD_CYC - 1));
  assign end_gap  = (cnt == CW'(SB_GAP - 1));
  assign end_num  = (cnt == CW'(NUM_CYC - 1));
  assign end_pgap = (cnt == CW'(PAIR_GAP - 1));
  assign end_tail = (cnt == CW'(TAIL_CYC - 1));

  mbs_pick #(.N(NSB), .NUM_W(SBN_W)) u_pick (
    .pend (pend),
    .num  (pick_num),
    .sel  (pick_sel),
    .any  (pend_any)
  );

  mbs_budget #(.BUDGET(SB_BUDGET)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (sb_enter),
    .at_limit (at_limit),
    .over     (over)
  );

  mbs_fld_mux #(.DW(DW), .MV_W(MV_W), .NSB(NSB)) u_mux (
    .fld    (fld),
    .ctrl   (h_ctrl),
    .gob    (h_gob),
    .mba    (h_mba),
    .quant  (h_quant),
    .mvx    (h_mvx),
    .mvy    (h_mvy),
    .cbp    (h_cbp),
    .byte_o (hdr_byte)
  );

  // Pair stream: ready only where the next pair is needed.
  always_comb begin
    pr_ready = ((st == S_NUM) && end_num) ||
               (st == S_STALL) ||
               ((st == S_PGAP) && end_pgap && !p_last);
  end
  assign take = pr_valid && pr_ready;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (start) st_n = S_PRE;
      S_PRE:   if (end_pre) st_n = S_FLD;
      S_FLD: begin
        if (end_fld) begin
          if (h_dummy) st_n = S_TAIL;
          else if (fld == F_MVY) st_n = pend_any ? S_GAP : S_TAIL;
        end
      end
      S_GAP:   if (end_gap) st_n = S_NUM;
      S_NUM:   if (end_num) st_n = take ? S_RUN : S_STALL;
      S_STALL: if (take) st_n = S_RUN;
      S_RUN:   if (end_fld) st_n = S_COEF;
      S_COEF:  if (end_fld) st_n = S_PGAP;
      S_PGAP: begin
        if (end_pgap) begin
          if (!p_last) st_n = take ? S_RUN : S_STALL;
          else if (over) st_n = pend_any ? S_NUM : S_TAIL;
          else st_n = S_PAD;
        end
      end
      S_PAD:   if (at_limit) st_n = pend_any ? S_NUM : S_TAIL;
      S_TAIL:  if (end_tail) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  assign sb_enter = (st_n == S_NUM) && (st != S_NUM);
  assign cnt_clr  = (st_n != st) || ((st == S_FLD) && end_fld);

  // Budget runs out while pairs are still due (the final gap cycle of a last pair is fine).
  always_comb begin
    ovf_set = 1'b0;
    if (at_limit) begin
      case (st)
        S_NUM, S_STALL, S_RUN, S_COEF: ovf_set = 1'b1;
        S_PGAP: ovf_set = !(p_last && end_pgap);
        default: ovf_set = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      fld     <= F_CTRL;
      pend    <= '0;
      sb_num  <= '0;
      p_run   <= '0;
      p_coef  <= '0;
      p_last  <= 1'b0;
      h_dummy <= 1'b0;
      h_ctrl  <= '0;
      h_gob   <= '0;
      h_mba   <= '0;
      h_quant <= '0;
      h_mvx   <= '0;
      h_mvy   <= '0;
      h_cbp   <= '0;
      ovf_err <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_clr ? '0 : cnt + 1'b1;
      if ((st == S_IDLE) && start) begin
        h_dummy <= hdr_dummy;
        h_ctrl  <= hdr_ctrl;
        h_gob   <= hdr_gob;
        h_mba   <= hdr_mba;
        h_quant <= hdr_quant;
        h_mvx   <= hdr_mvx;
        h_mvy   <= hdr_mvy;
        h_cbp   <= hdr_cbp;
        pend    <= hdr_dummy ? '0 : hdr_cbp;
      end
      if (st == S_PRE) begin
        fld <= F_CTRL;
      end else if ((st == S_FLD) && end_fld && (fld != F_MVY)) begin
        fld <= mbs_fld_e'(fld + 3'd1);
      end
      if (sb_enter) begin
        sb_num <= pick_num;
        pend   <= pend & ~pick_sel;
      end
      if (take) begin
        p_run  <= pr_run;
        p_coef <= pr_coef;
        p_last <= pr_last;
      end
      if (ovf_set) ovf_err <= 1'b1;
    end
  end

  always_comb begin
    case (st)
      S_FLD:   dbus = hdr_byte;
      S_NUM:   dbus = DW'(sb_num);
      S_RUN:   dbus = {p_last, p_last, p_run};
      S_COEF:  dbus = p_coef;
      default: dbus = '0;
    endcase
  end

  assign dclk   = (cnt == '0) &&
                  ((st == S_FLD) || (st == S_NUM) || (st == S_RUN) || (st == S_COEF));
  assign busy   = (st != S_IDLE);
  assign mb_end = (st == S_TAIL) && end_tail;

  // R11: a strobe is never followed by another strobe.
  a_r11_dclk_single: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |=> !dclk);

  // R3: a strobed byte is still on the bus in the next cycle.
  a_r3_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |=> $stable(dbus));

  // R10: overflow flag never clears without reset.
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R9: an accepted pair shows up as a strobed run byte next cycle.
  a_r9_take_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && pr_ready) |=> (dclk && (dbus[RUN_W-1:0] == $past(pr_run))));

  // R13: the end pulse is followed by idle.
  a_r13_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mb_end |=> !busy);

  // R6: a strobed sub-block number lies in 1..NSB.
  a_r6_num_range: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_NUM) && dclk) |-> ((dbus != '0) && (dbus <= DW'(NSB))));

  // R8: padding does not end before the budget is reached.
  a_r8_pad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_PAD) && !at_limit) |=> (st == S_PAD));

endmodule

// File: tb/mbs_out_seq_tb.sv
`timescale 1ns/1ps
module mbs_out_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, mb_end, ovf_err;
  logic       hdr_dummy = 1'b0;
  logic [7:0] hdr_ctrl = '0, hdr_gob = '0, hdr_mba = '0, hdr_quant = '0;
  logic [4:0] hdr_mvx = '0, hdr_mvy = '0;
  logic [5:0] hdr_cbp = '0;
  logic       pr_valid, pr_ready, pr_last;
  logic [5:0] pr_run;
  logic [7:0] pr_coef;
  logic [7:0] dbus;
  logic       dclk;

  always #2 clk = ~clk;

  mbs_out_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mb_end(mb_end),
    .ovf_err(ovf_err), .hdr_dummy(hdr_dummy), .hdr_ctrl(hdr_ctrl),
    .hdr_gob(hdr_gob), .hdr_mba(hdr_mba), .hdr_quant(hdr_quant),
    .hdr_mvx(hdr_mvx), .hdr_mvy(hdr_mvy), .hdr_cbp(hdr_cbp),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_run(pr_run),
    .pr_coef(pr_coef), .pr_last(pr_last), .dbus(dbus), .dclk(dclk)
  );

  int n_chk = 0;
  int n_err = 0;
  int tick = 0;
  always @(posedge clk) tick <= tick + 1;

  // pair source
  logic [5:0] fb_run [512];
  logic [7:0] fb_coef [512];
  logic       fb_last [512];
  int         fbn = 0;
  int         pidx = 0;
  logic       stall_r = 1'b0;
  bit         stall_mode = 0;
  assign pr_valid = (pidx < fbn) && !stall_r;
  assign pr_run   = (pidx < fbn) ? fb_run[pidx] : 6'd0;
  assign pr_coef  = (pidx < fbn) ? fb_coef[pidx] : 8'd0;
  assign pr_last  = (pidx < fbn) ? fb_last[pidx] : 1'b0;
  always @(posedge clk) if (pr_valid && pr_ready) pidx <= pidx + 1;
  always @(negedge clk) stall_r <= stall_mode ? ($urandom % 2 == 0) : 1'b0;

  // recorder
  int         t0 = 0;
  bit         rec_on = 0;
  int         nev = 0;
  int         ev_t [1024];
  logic [7:0] ev_b [1024];
  logic [7:0] bus_at [4096];
  bit         got_end = 0;
  int         end_t = 0;
  always @(negedge clk) begin
    if (rec_on) begin
      int rel;
      rel = tick - t0;
      if (rel >= 0 && rel < 4095) bus_at[rel] = dbus;
      if (dclk && nev < 1024) begin
        ev_t[nev] = rel;
        ev_b[nev] = dbus;
        nev++;
      end
      if (mb_end && !got_end) begin
        got_end = 1;
        end_t = rel;
      end
    end
  end

  // model
  logic       m_dummy;
  logic [7:0] m_ctrl, m_gob, m_mba, m_quant;
  logic [4:0] m_mvx, m_mvy;
  logic [5:0] m_cbp;
  int         np [6];
  logic [5:0] prun [6][72];
  logic [7:0] pcoef [6][72];
  int         ne;
  int         exp_t [1024];
  logic [7:0] exp_b [1024];
  string      exp_tag [1024];
  bit         exp_pair [1024];
  int         exp_end;
  bit         exp_ovf = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic add_ev(input int t, input logic [7:0] b, input string tag, input bit pr);
    exp_t[ne] = t; exp_b[ne] = b; exp_tag[ne] = tag; exp_pair[ne] = pr; ne++;
  endtask

  function automatic logic [7:0] cbp_byte(input logic [5:0] c);
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < 6; i++) b[6-i] = c[i];
    return b;
  endfunction

  task automatic fill_sb(input int sb, input int n);
    np[sb] = n;
    for (int i = 0; i < n; i++) begin
      prun[sb][i]  = 6'($urandom % 64);
      pcoef[sb][i] = 8'(1 + $urandom % 255);
      if (i == n - 1 && ($urandom % 2 == 0)) pcoef[sb][i] = 8'd0;
    end
  endtask

  task automatic build_model();
    int s;
    ne = 0;
    fbn = 0;
    add_ev(2, m_ctrl, "R3,R12", 0);
    if (m_dummy) begin
      exp_end = 4;
      return;
    end
    add_ev(4, m_gob, "R3", 0);
    add_ev(6, m_mba, "R3", 0);
    add_ev(8, cbp_byte(m_cbp), "R4", 0);
    add_ev(10, m_quant, "R3", 0);
    add_ev(12, {3'b000, m_mvx}, "R4", 0);
    add_ev(14, {3'b000, m_mvy}, "R4", 0);
    if (m_cbp == 6'd0) begin
      exp_end = 16;
      return;
    end
    s = 48;
    for (int sb = 0; sb < 6; sb++) begin
      if (m_cbp[sb]) begin
        int len;
        add_ev(s, 8'(sb + 1), (s == 48) ? "R6" : "R8", 0);
        for (int i = 0; i < np[sb]; i++) begin
          bit lst;
          lst = (i == np[sb] - 1);
          add_ev(s + 15 + 5 * i, {lst, lst, prun[sb][i]}, "R7", 1);
          add_ev(s + 17 + 5 * i, pcoef[sb][i], "R7", 1);
          fb_run[fbn] = prun[sb][i]; fb_coef[fbn] = pcoef[sb][i]; fb_last[fbn] = lst;
          fbn++;
        end
        len = 15 + 5 * np[sb];
        if (len > 335) exp_ovf = 1;
        else len = 335;
        s += len;
      end
    end
    exp_end = s;
  endtask

  task automatic rand_hdr();
    hdr_ctrl = 8'($urandom); hdr_gob = 8'($urandom); hdr_mba = 8'($urandom);
    hdr_quant = 8'($urandom); hdr_mvx = 5'($urandom); hdr_mvy = 5'($urandom);
  endtask

  task automatic run_mb(input logic dmy, input logic [5:0] cbp, input bit stl, input bit poke);
    int guard;
    rand_hdr();
    hdr_dummy = dmy; hdr_cbp = cbp;
    m_dummy = dmy; m_cbp = cbp; m_ctrl = hdr_ctrl; m_gob = hdr_gob; m_mba = hdr_mba;
    m_quant = hdr_quant; m_mvx = hdr_mvx; m_mvy = hdr_mvy;
    stall_mode = 0;
    @(negedge clk);
    pidx = 0;
    build_model();
    start = 1'b1; t0 = tick + 1; nev = 0; got_end = 0; rec_on = 1;
    @(negedge clk);
    start = 1'b0;
    stall_mode = stl;
    // R12: header pins change after acceptance
    rand_hdr(); hdr_dummy = ~dmy; hdr_cbp = ~cbp;
    chk(busy === 1'b1, "R1", "busy after accept", busy, 1);
    guard = 0;
    while (!got_end && guard < 6000) begin
      if (poke && guard == 20) begin
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
      @(posedge clk);
      guard++;
    end
    stall_mode = 0;
    chk(got_end, "R13", "end pulse seen", got_end, 1);
    @(negedge clk);
    chk(busy === 1'b0, "R13", "idle after end", busy, 0);
    chk(mb_end === 1'b0, "R13", "end pulse one cycle", mb_end, 0);
    chk(end_t == exp_end, "R8,R13", "end cycle", end_t, exp_end);
    chk(nev == ne, "R11", "strobe count", nev, ne);
    for (int i = 0; i < ne && i < nev; i++) begin
      chk(ev_b[i] == exp_b[i], exp_tag[i], "strobed byte", ev_b[i], exp_b[i]);
      if (!(stl && exp_pair[i])) begin
        chk(ev_t[i] == exp_t[i], exp_tag[i], "strobe cycle", ev_t[i], exp_t[i]);
        chk(bus_at[exp_t[i] + 1] == exp_b[i], "R3", "byte held", bus_at[exp_t[i] + 1], exp_b[i]);
      end
    end
    chk(pidx == fbn, "R9", "pairs consumed", pidx, fbn);
    chk(ovf_err === exp_ovf, "R10", "overflow flag", ovf_err, exp_ovf);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(busy === 1'b0, "R1", "start while busy ignored", busy, 0);
      end
    end
    rec_on = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_ovf = 0;
    @(negedge clk);
    chk(busy === 1'b0, "R1", "reset busy", busy, 0);
    chk(dclk === 1'b0, "R1", "reset dclk", dclk, 0);
    chk(dbus === 8'd0, "R1", "reset dbus", dbus, 0);
    chk(pr_ready === 1'b0, "R1", "reset ready", pr_ready, 0);
    chk(mb_end === 1'b0, "R1", "reset end", mb_end, 0);
    chk(ovf_err === 1'b0, "R10", "reset overflow", ovf_err, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R2 dummy, R5 no coded blocks
    run_mb(1'b1, 6'b101010, 0, 0);
    run_mb(1'b0, 6'b000000, 0, 0);
    // R6 R7 R8: exact budget fit and single pair, outer sub-blocks only
    fill_sb(0, 64); fill_sb(5, 1);
    run_mb(1'b0, 6'b100001, 0, 0);
    // R4 pattern mapping with every sub-block coded
    for (int sb = 0; sb < 6; sb++) fill_sb(sb, 1 + $urandom % 4);
    run_mb(1'b0, 6'b111111, 0, 0);
    // R1 start while busy
    fill_sb(2, 3);
    run_mb(1'b0, 6'b000100, 0, 1);
    // random mix
    for (int r = 0; r < 8; r++) begin
      for (int sb = 0; sb < 6; sb++) fill_sb(sb, 1 + $urandom % 20);
      run_mb(($urandom % 8) == 0, 6'($urandom), 0, 0);
    end
    // R9 stalls on the pair stream
    for (int r = 0; r < 3; r++) begin
      for (int sb = 0; sb < 6; sb++) fill_sb(sb, 1 + $urandom % 25);
      run_mb(1'b0, 6'($urandom) | 6'b000001, 1, 0);
    end
    // R10 overflow: 65 pairs, then sticky, then cleared by reset
    fill_sb(2, 65); fill_sb(4, 2);
    run_mb(1'b0, 6'b010100, 0, 0);
    fill_sb(1, 2);
    run_mb(1'b0, 6'b000010, 0, 0);
    do_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule